// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a 10-bit parallel word (8 data bits plus 2 control bits) into a 12-bit serial frame. The frame carries its own clock edge, so a receiver can recover timing from the line alone. All logic runs on one fast system clock. A bit-rate clock enable, `bit_en`, paces the serial output, so one frame is twelve enabled cycles and the bit rate is twelve times the word rate.

The parallel side supplies a word clock as an ordinary signal. The block synchronizes it and detects either its rising or its falling edge, chosen by `edge_sel`. On that edge the word is captured into a holding register. The holding register feeds the shift register only at a frame boundary, so a frame is never torn. When `sync_req` is held, training frames replace the data frames so that a receiver can lock within a bounded time.

`out_en` asks for the line to be driven, and `ser_oe` tells the external driver when to leave high impedance. `pdn` stops the serial side and freezes the holding register.

Top module: `ecs_serializer`

## Requirements
- R1: While `rst` is high and afterwards, `ser_out` and `ser_oe` are 0. `ser_out` stays 0 until the first cycle with `bit_en` high.
- R2: A data frame is sent least significant bit first as serial bit 0 to bit 11. Bit 0 is a start bit of 1. Bits 1 to 10 are word bits 0 to 9. Bit 11 is a stop bit of 0. Each bit appears on `ser_out` the clock after the enabled edge that selects it.
- R3: Frames follow one another with no gap, twelve enabled bits each. The stop bit 0 of one frame is followed directly by the start bit 1 of the next, which gives a guaranteed 0-to-1 edge at every boundary.
- R4: When `sync_req` is high at a frame boundary, the next frame is a training frame: six 1s followed by six 0s. The choice is made only at boundaries, so changing `sync_req` within a frame does not alter that frame.
- R5: `edge_sel` = 0 captures `din` on a rising edge of `word_clk`. `edge_sel` = 1 captures it on a falling edge.
- R6: A word captured in the middle of a frame does not change that frame. It goes out in the next frame.
- R7: When no new word is captured, each following frame repeats the last word held. After reset the held word is 0.
- R8: `ser_oe` equals `out_en` AND NOT `pdn`, registered one clock later.
- R9: While `pdn` is high, `ser_out` and `ser_oe` read 0 one clock later. Word-clock edges seen during `pdn` do not change the held word.
- R10: After `pdn` falls, `ser_out` stays 0 until the first cycle with `bit_en` high. That cycle begins a complete frame.
- R11: In a cycle with `bit_en` low and `pdn` low, `ser_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn | input | 1 | Powerdown: stops the serial side and freezes the held word |
| word_clk | input | 1 | Parallel word clock, sampled as data |
| edge_sel | input | 1 | 0 = capture on the rising word-clock edge, 1 = capture on the falling edge |
| din | input | 10 | Parallel word: 8 data bits and 2 control bits |
| sync_req | input | 1 | Send training frames instead of data |
| bit_en | input | 1 | Bit-rate clock enable |
| out_en | input | 1 | Request to drive the serial line |
| ser_out | output | 1 | Serial bit stream |
| ser_oe | output | 1 | Line driver enable; 0 means high impedance |

## Verification
The bench builds the block with its default parameters: a 10-bit word and a two-stage word-clock synchronizer. That gives 12-bit frames, so two or three back-to-back frames take only a few dozen cycles. Boundary behaviour can therefore be observed directly: the stop-to-start edge, `sync_req` changing inside a frame, and a word arriving inside a frame. A run with `bit_en` high only every other cycle confirms that the enable alone sets the bit rate.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ecs_word_capture.sv
module ecs_word_capture #(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn,
  input  logic              word_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold
);
  import ecs_pkg::*;

  logic [SYNC_STAGES:0] sync_q;
  logic                 cur_lvl, prev_lvl, take;

  // synchronizer chain plus one history stage
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], word_clk};
  end

  assign cur_lvl  = sync_q[SYNC_STAGES-1];
  assign prev_lvl = sync_q[SYNC_STAGES];

  always_comb begin
    if (edge_sel_e'(edge_sel) == EDGE_FALL) take = prev_lvl & ~cur_lvl;
    else                                    take = cur_lvl & ~prev_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)              hold <= '0;
    else if (take && !pdn) hold <= din;
  end

  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    pdn |=> $stable(hold));
endmodule

// File: rtl/ecs_frame_shifter.sv
module ecs_frame_shifter #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn,
  input  logic              bit_en,
  input  logic              sync_req,
  input  logic [DATA_W-1:0] hold,
  output logic              ser_bit
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int ONES_W  = FRAME_W / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] train_frame();
    logic [FRAME_W-1:0] f;
    for (int i = 0; i < FRAME_W; i++) f[i] = (i < ONES_W);
    return f;
  endfunction

  localparam logic [FRAME_W-1:0] TRAIN = train_frame();

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   idx_q;
  logic               run_q;
  logic               boundary;
  logic [FRAME_W-1:0] next_frame;

  assign boundary   = !run_q || (idx_q == LAST);
  assign next_frame = sync_req ? TRAIN : {1'b0, hold, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || pdn) begin
      sr_q  <= '0;
      idx_q <= '0;
      run_q <= 1'b0;
    end else if (bit_en) begin
      if (boundary) begin
        sr_q  <= next_frame;
        idx_q <= '0;
        run_q <= 1'b1;
      end else begin
        sr_q  <= sr_q >> 1;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign ser_bit = sr_q[0];

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && idx_q == '0) |-> sr_q[0]);
  assert_stop_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && idx_q == LAST) |-> !sr_q[0]);
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);
  assert_hold_bit_R11: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !pdn) |=> (pdn || $stable(ser_bit)));
  assert_pdn_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    pdn |=> !ser_bit);
endmodule

// File: rtl/ecs_serializer.sv
module ecs_serializer #(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn,
  input  logic              word_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] din,
  input  logic              sync_req,
  input  logic              bit_en,
  input  logic              out_en,
  output logic              ser_out,
  output logic              ser_oe
);
  logic [DATA_W-1:0] hold;
  logic              oe_q;

  ecs_word_capture #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst(rst), .pdn(pdn), .word_clk(word_clk),
    .edge_sel(edge_sel), .din(din), .hold(hold)
  );

  ecs_frame_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .pdn(pdn), .bit_en(bit_en),
    .sync_req(sync_req), .hold(hold), .ser_bit(ser_out)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= out_en & ~pdn;
  end

  assign ser_oe = oe_q;

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
    pdn |=> !ser_oe);
  assert_oe_on_R8: assert property (@(posedge clk) disable iff (rst)
    (out_en && !pdn) |=> ser_oe);
endmodule

// File: tb/test_ecs_serializer.sv
module test_ecs_serializer;
  logic clk = 1'b0, rst = 1'b1, pdn = 1'b0, word_clk = 1'b0, edge_sel = 1'b0;
  logic [9:0] din = '0;
  logic sync_req = 1'b0, bit_en = 1'b0, out_en = 1'b1;
  logic ser_out, ser_oe;
  int n_chk = 0, n_fail = 0;

  ecs_serializer i_ecs_serializer (
    .clk(clk), .rst(rst), .pdn(pdn), .word_clk(word_clk), .edge_sel(edge_sel),
    .din(din), .sync_req(sync_req), .bit_en(bit_en), .out_en(out_en),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always #5 clk = ~clk;

  localparam logic [11:0] TRAIN = 12'h03F;

  function automatic logic [11:0] dframe(input logic [9:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send_word(input logic [9:0] w);
    @(negedge clk); din = w; word_clk = 1'b1;
    repeat (5) @(negedge clk);
    word_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // powerdown pulse, then bit_en high: the next sample is bit 0 of a frame
  task automatic restart();
    @(negedge clk); pdn = 1'b1; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    pdn = 1'b0; bit_en = 1'b1;
  endtask

  task automatic collect(input int n, output logic [47:0] log);
    log = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); log[i] = ser_out;
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 ser_out in reset", ser_out, 0);
    chk("R1 ser_oe in reset", ser_oe, 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 ser_out idle before bit_en", ser_out, 0);
    end
  endtask

  task automatic t_frame();
    logic [47:0] log;
    bit_en = 1'b0;
    send_word(10'h2B5);
    restart();
    collect(24, log);
    chk("R2 data frame", log[11:0], dframe(10'h2B5));
    chk("R3 second frame back to back", log[23:12], dframe(10'h2B5));
    chk("R3 stop then start edge", {log[12], log[11]}, 2'b10);
  endtask

  task automatic t_sync();
    logic [47:0] log;
    send_word(10'h155);
    sync_req = 1'b1;
    restart();
    log = '0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk); log[i] = ser_out;
      if (i == 5) sync_req = 1'b0;
    end
    chk("R4 training frame kept after mid-frame drop", log[11:0], TRAIN);
    chk("R4 data resumes at boundary", log[23:12], dframe(10'h155));
    sync_req = 1'b1;
    restart();
    collect(24, log);
    sync_req = 1'b0;
    chk("R4 training frame 1", log[11:0], TRAIN);
    chk("R4 training frame repeats", log[23:12], TRAIN);
  endtask

  task automatic two_edge_word(input logic [9:0] a, input logic [9:0] b);
    @(negedge clk); din = a; word_clk = 1'b1;
    repeat (5) @(negedge clk);
    din = b;
    @(negedge clk); word_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_edge();
    logic [47:0] log;
    bit_en = 1'b0;
    edge_sel = 1'b1;
    two_edge_word(10'h0F3, 10'h30C);
    restart();
    collect(12, log);
    chk("R5 falling edge capture", log[11:0], dframe(10'h30C));
    bit_en = 1'b0;
    edge_sel = 1'b0;
    two_edge_word(10'h0F3, 10'h30C);
    restart();
    collect(12, log);
    chk("R5 rising edge capture", log[11:0], dframe(10'h0F3));
  endtask

  task automatic t_tear();
    logic [47:0] log;
    bit_en = 1'b0;
    send_word(10'h0AA);
    restart();
    log = '0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk); log[i] = ser_out;
      if (i == 2) begin din = 10'h3C1; word_clk = 1'b1; end
      if (i == 8) word_clk = 1'b0;
    end
    chk("R6 current frame untouched", log[11:0], dframe(10'h0AA));
    chk("R6 new word in next frame", log[23:12], dframe(10'h3C1));
    chk("R7 word repeats", log[35:24], dframe(10'h3C1));
  endtask

  task automatic t_oe();
    @(negedge clk); out_en = 1'b0;
    @(negedge clk);
    chk("R8 oe follows out_en low", ser_oe, 0);
    out_en = 1'b1;
    @(negedge clk);
    chk("R8 oe follows out_en high", ser_oe, 1);
  endtask

  task automatic t_pdn();
    logic [47:0] log;
    bit_en = 1'b0;
    send_word(10'h1E7);
    bit_en = 1'b1;
    @(negedge clk); pdn = 1'b1;
    @(negedge clk);
    chk("R9 ser_out low in powerdown", ser_out, 0);
    chk("R9 ser_oe low in powerdown", ser_oe, 0);
    send_word(10'h018);
    chk("R9 ser_out still low", ser_out, 0);
    restart();
    collect(12, log);
    chk("R9 word edge ignored in powerdown", log[11:0], dframe(10'h1E7));
  endtask

  task automatic t_wake();
    logic [47:0] log;
    @(negedge clk); pdn = 1'b1; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    pdn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 low after wake before bit_en", ser_out, 0);
    end
    bit_en = 1'b1;
    collect(12, log);
    chk("R10 first frame complete", log[11:0], dframe(10'h1E7));
  endtask

  task automatic t_gap();
    logic [47:0] log;
    logic [11:0] exp;
    bit_en = 1'b0;
    send_word(10'h2C6);
    restart();
    log = '0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); log[i] = ser_out;
      bit_en = i[0];
    end
    exp = dframe(10'h2C6);
    for (int k = 0; k < 12; k++)
      chk("R11 bit held while bit_en low", {log[2*k+1], log[2*k]}, {exp[k], exp[k]});
    bit_en = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    t_reset();
    t_frame();
    t_sync();
    t_edge();
    t_tear();
    t_oe();
    t_pdn();
    t_wake();
    t_gap();
    finish_up();
  end
endmodule